// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps the rows of a two-block SDRAM alive. A down-counter measures the refresh interval in bus clocks. Software computes that interval from the per-row refresh time and the bus frequency, then loads it as a plain count. For example, 15.625 us per row at 60 MHz is about 937 clocks. When the interval runs out and the access sequencer reports idle, the block issues a one-cycle REFRESH strobe. That strobe selects every block whose auto-refresh is switched on. The block then holds a recovery window of 3, 6 or 9 clocks, during which no ACTIVE may follow.

Software drives the block through a one-deep command port. The commands switch auto-refresh on or off for one block, and enter or leave self-refresh. Self-refresh always covers both blocks, whatever block is selected. The sequencer reads the busy and refresh-active flags to decide when it may use the command bus.

Top module: `sdr_refresh_sched`

## Requirements
- R1: After reset, no REFRESH is issued. `cmd_rdy_o` is 1. `busy_o`, `ref_active_o`, `self_ref_o`, `cmd_done_o` and `ref_cs_o` are all 0.
- R2: While at least one block has auto-refresh on and the sequencer stays idle, REFRESH strobes come exactly `interval_i` clocks apart. The counter reloads when an auto-refresh-on command is accepted, so the first REFRESH comes `interval_i` clocks after that acceptance edge.
- R3: `ref_active_o` rises in the REFRESH cycle and stays high for a number of clocks set by `recov_sel_i`, sampled at issue: code 0 gives 3 clocks, code 1 gives 6, and codes 2 and 3 give 9. The strobe `ref_cmd_o` lasts one cycle. `cmd_rdy_o` is low throughout the recovery window.
- R4: Auto-refresh is switched on and off per block, with the block chosen by `cmd_blk_i` (0 or 1). While `ref_cmd_o` is high, `ref_cs_o` bit b is 1 exactly when block b has auto-refresh on. At all other times `ref_cs_o` is 0.
- R5: While no block has auto-refresh on, no REFRESH is issued and `busy_o` stays low outside self-refresh.
- R6: A refresh that falls due while `seq_idle_i` is 0 is held pending, with `busy_o` high and `cmd_rdy_o` low. It is issued on the first edge where `seq_idle_i` is 1. However long the wait, only one REFRESH results.
- R7: Self-refresh entry and exit ignore `cmd_blk_i`. In self-refresh, `self_ref_o` and `busy_o` are 1 and no REFRESH is issued. After exit, the next REFRESH comes `interval_i` clocks after the exit acceptance edge.
- R8: A self-refresh entry request is not accepted while a refresh is pending or recovering. The pending REFRESH is issued first, and self-refresh starts only after recovery ends.
- R9: The command port accepts one command on each edge where `cmd_vld_i` and `cmd_rdy_o` are both 1. `cmd_done_o` pulses in the following cycle. The opcodes on `cmd_op_i` are: 1 = auto-refresh on, 2 = auto-refresh off, 3 = enter self-refresh, 4 = leave self-refresh. Other codes are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| interval_i | input | CNT_W | Refresh interval in bus clocks |
| recov_sel_i | input | 2 | Recovery-time code |
| cmd_vld_i | input | 1 | Command request |
| cmd_op_i | input | 3 | Command opcode |
| cmd_blk_i | input | BLK_W | Target block for auto-refresh on/off |
| cmd_rdy_o | output | 1 | Command can be accepted this cycle |
| cmd_done_o | output | 1 | One-cycle pulse after each accepted command |
| seq_idle_i | input | 1 | Access sequencer has no access in flight |
| ref_cmd_o | output | 1 | One-cycle REFRESH strobe |
| ref_cs_o | output | NBLK | Blocks selected by the REFRESH strobe |
| ref_active_o | output | 1 | REFRESH-to-ACTIVE recovery in progress |
| busy_o | output | 1 | Refresh pending, recovering, or self-refresh |
| self_ref_o | output | 1 | Both blocks in self-refresh |

## Verification
An interval counter that is off by one shows up as a REFRESH one cycle early or late. This appears at the first strobe after enable and grows over successive strobes, so spacing is measured exactly, edge to edge. A wrong recovery timer shows in the length of `ref_active_o` within nine cycles of the strobe. A lost pending flag shows in two ways: no strobe on the first idle edge, or a burst of strobes after a long stall. Mode or enable-mask faults show as strobes during self-refresh, or as a wrong `ref_cs_o` on the very next REFRESH.

// File: rtl/sdr_rf_pkg.sv
package sdr_rf_pkg;

   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_AR_ON  = 3'd1,
      OP_AR_OFF = 3'd2,
      OP_SR_IN  = 3'd3,
      OP_SR_OUT = 3'd4
   } rf_op_e;

   typedef enum logic {
      MODE_LIVE = 1'b0,
      MODE_SELF = 1'b1
   } rf_mode_e;

   // recovery length in clocks for a 2-bit code; codes 2 and 3 share the longest
   function automatic int unsigned gap_clocks(input logic [1:0] code, input int unsigned unit);
      case (code)
         2'd0:    return unit;
         2'd1:    return 2 * unit;
         default: return 3 * unit;
      endcase
   endfunction

endpackage

// File: rtl/sdr_rf_ivl_cnt.sv
module sdr_rf_ivl_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] ivl_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   // counting down to zero from ivl-1 spaces events exactly ivl clocks apart
   assign reload = (ivl_i == '0) ? '0 : ivl_i - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= reload;
      end else if (run_i && cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdr_rf_recov.sv
module sdr_rf_recov
   import sdr_rf_pkg::*;
#(
   parameter int RECOV_UNIT = 3,
   localparam int REC_W     = $clog2(3 * RECOV_UNIT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [1:0] sel_i,
   output logic       active_o
);

   logic [REC_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (start_i) begin
         rem_q <= REC_W'(gap_clocks(sel_i, RECOV_UNIT));
      end else if (rem_q != '0) begin
         rem_q <= rem_q - REC_W'(1);
      end
   end

   assign active_o = (rem_q != '0);

endmodule

// File: rtl/sdr_rf_blk_en.sv
module sdr_rf_blk_en #(
   parameter int NBLK    = 2,
   localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [BLK_W-1:0] blk_i,
   output logic [NBLK-1:0]  mask_o
);

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      logic hit;
      assign hit = (blk_i == BLK_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_o[b] <= 1'b0;
         end else if (set_i && hit) begin
            mask_o[b] <= 1'b1;
         end else if (clr_i && hit) begin
            mask_o[b] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
   import sdr_rf_pkg::*;
#(
   parameter int NBLK       = 2,
   parameter int CNT_W      = 16,
   parameter int RECOV_UNIT = 3,
   localparam int BLK_W     = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] interval_i,
   input  logic [1:0]       recov_sel_i,
   input  logic             cmd_vld_i,
   input  logic [2:0]       cmd_op_i,
   input  logic [BLK_W-1:0] cmd_blk_i,
   output logic             cmd_rdy_o,
   output logic             cmd_done_o,
   input  logic             seq_idle_i,
   output logic             ref_cmd_o,
   output logic [NBLK-1:0]  ref_cs_o,
   output logic             ref_active_o,
   output logic             busy_o,
   output logic             self_ref_o
);

   if (NBLK < 1) begin : g_bad_nblk
      $error("NBLK must be at least 1");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must be at least 4");
   end
   if (RECOV_UNIT < 1) begin : g_bad_unit
      $error("RECOV_UNIT must be at least 1");
   end

   rf_op_e          op;
   rf_mode_e        mode_q;
   logic [NBLK-1:0] en_mask;
   logic            any_en, zero, due, rec_active, issue, acc, load, run;
   logic            ref_cmd_q, done_q;
   logic [NBLK-1:0] ref_cs_q;

   assign op     = rf_op_e'(cmd_op_i);
   assign any_en = |en_mask;
   assign due    = zero && any_en && (mode_q == MODE_LIVE);

   // a pending or recovering refresh blocks new commands; self-refresh always listens
   assign cmd_rdy_o = (mode_q == MODE_SELF) || (!rec_active && !due);
   assign acc       = cmd_vld_i && cmd_rdy_o;
   assign issue     = (mode_q == MODE_LIVE) && due && !rec_active && seq_idle_i;

   assign load = issue
              || (acc && op == OP_AR_ON)
              || (acc && op == OP_SR_OUT && mode_q == MODE_SELF);
   assign run  = any_en && (mode_q == MODE_LIVE);

   sdr_rf_ivl_cnt #(.CNT_W(CNT_W)) u_ivl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .run_i  (run),
      .ivl_i  (interval_i),
      .zero_o (zero)
   );

   sdr_rf_recov #(.RECOV_UNIT(RECOV_UNIT)) u_recov (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (issue),
      .sel_i    (recov_sel_i),
      .active_o (rec_active)
   );

   sdr_rf_blk_en #(.NBLK(NBLK)) u_blk (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (acc && op == OP_AR_ON),
      .clr_i  (acc && op == OP_AR_OFF),
      .blk_i  (cmd_blk_i),
      .mask_o (en_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_LIVE;
         ref_cmd_q <= 1'b0;
         ref_cs_q  <= '0;
         done_q    <= 1'b0;
      end else begin
         ref_cmd_q <= issue;
         ref_cs_q  <= issue ? en_mask : '0;
         done_q    <= acc;
         if (acc && op == OP_SR_IN) begin
            mode_q <= MODE_SELF;
         end else if (acc && op == OP_SR_OUT) begin
            mode_q <= MODE_LIVE;
         end
      end
   end

   assign ref_cmd_o    = ref_cmd_q;
   assign ref_cs_o     = ref_cs_q;
   assign cmd_done_o   = done_q;
   assign ref_active_o = rec_active;
   assign self_ref_o   = (mode_q == MODE_SELF);
   assign busy_o       = rec_active || due || (mode_q == MODE_SELF);

endmodule

// File: rtl/sdr_refresh_sched_chk.sv
module sdr_refresh_sched_chk #(
   parameter int NBLK = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_vld_i,
   input logic            cmd_rdy_o,
   input logic            cmd_done_o,
   input logic            seq_idle_i,
   input logic            ref_cmd_o,
   input logic [NBLK-1:0] ref_cs_o,
   input logic            ref_active_o,
   input logic            self_ref_o
);

   // R3
   ref_opens_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd_o |-> ref_active_o);

   // R3
   ref_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd_o |=> !ref_cmd_o);

   // R3
   rdy_low_in_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_active_o && !self_ref_o) |-> !cmd_rdy_o);

   // R4
   cs_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd_o |-> (ref_cs_o != '0));

   // R4
   cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_cmd_o |-> (ref_cs_o == '0));

   // R6
   ref_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd_o |-> $past(seq_idle_i));

   // R7
   no_ref_in_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_ref_o |-> !ref_cmd_o);

   // R8
   self_entry_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(self_ref_o) |-> !ref_active_o);

   // R9
   done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_i && cmd_rdy_o) |=> cmd_done_o);

endmodule

bind sdr_refresh_sched sdr_refresh_sched_chk #(.NBLK(NBLK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_vld_i    (cmd_vld_i),
   .cmd_rdy_o    (cmd_rdy_o),
   .cmd_done_o   (cmd_done_o),
   .seq_idle_i   (seq_idle_i),
   .ref_cmd_o    (ref_cmd_o),
   .ref_cs_o     (ref_cs_o),
   .ref_active_o (ref_active_o),
   .self_ref_o   (self_ref_o)
);

// File: tb/test_sdr_refresh_sched.sv
module test_sdr_refresh_sched;

   localparam int N = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] interval_i = 16'(N);
   logic [1:0]  recov_sel_i = 2'd0;
   logic        cmd_vld_i = 1'b0;
   logic [2:0]  cmd_op_i = 3'd0;
   logic [0:0]  cmd_blk_i = 1'b0;
   logic        seq_idle_i = 1'b1;
   logic        cmd_rdy_o, cmd_done_o, ref_cmd_o, ref_active_o, busy_o, self_ref_o;
   logic [1:0]  ref_cs_o;

   always #4 clk = ~clk;

   sdr_refresh_sched i_sdr_refresh_sched (
      .clk(clk), .rst_n(rst_n), .interval_i(interval_i), .recov_sel_i(recov_sel_i),
      .cmd_vld_i(cmd_vld_i), .cmd_op_i(cmd_op_i), .cmd_blk_i(cmd_blk_i),
      .cmd_rdy_o(cmd_rdy_o), .cmd_done_o(cmd_done_o), .seq_idle_i(seq_idle_i),
      .ref_cmd_o(ref_cmd_o), .ref_cs_o(ref_cs_o), .ref_active_o(ref_active_o),
      .busy_o(busy_o), .self_ref_o(self_ref_o)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0, ref_count = 0, last_ref_cyc = 0, act_run = 0, last_act_len = 0, acc_cyc = 0;
   logic [1:0] last_cs = 2'b00;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ref_cmd_o) begin
            ref_count++;
            last_ref_cyc = cyc;
            last_cs = ref_cs_o;
         end
         if (ref_active_o) act_run++;
         else if (act_run != 0) begin
            last_act_len = act_run;
            act_run = 0;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic send_cmd(input logic [2:0] op, input logic blk);
      cmd_vld_i = 1'b1; cmd_op_i = op; cmd_blk_i = blk;
      while (!cmd_rdy_o) tick();
      tick();
      acc_cyc = cyc;
      cmd_vld_i = 1'b0; cmd_op_i = 3'd0;
      chk("R9 done pulse", int'(cmd_done_o), 1);
   endtask

   task automatic wait_ref(input int limit);
      int c0 = ref_count;
      for (int k = 0; k < limit && ref_count == c0; k++) tick();
      chk("R2 refresh seen", int'(ref_count != c0), 1);
   endtask

   // interval, recovery code, expected recovery clocks
   localparam int VEC [4][3] = '{'{20, 0, 3}, '{25, 1, 6}, '{30, 2, 9}, '{17, 3, 9}};

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int c0, prev;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1
      chk("R1 rdy", int'(cmd_rdy_o), 1);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 ref", int'(ref_cmd_o), 0);
      chk("R1 self", int'(self_ref_o), 0);
      chk("R1 active", int'(ref_active_o), 0);
      chk("R1 done", int'(cmd_done_o), 0);
      chk("R1 cs", int'(ref_cs_o), 0);

      for (int i = 0; i < 4; i++) begin
         interval_i  = 16'(VEC[i][0]);
         recov_sel_i = 2'(VEC[i][1]);
         send_cmd(3'd1, 1'b0);
         wait_ref(VEC[i][0] + 4);
         chk("R2 first delay", last_ref_cyc - acc_cyc, VEC[i][0]);
         chk("R3 rdy low at ref", int'(cmd_rdy_o), 0);
         prev = last_ref_cyc;
         wait_ref(VEC[i][0] + 4);
         chk("R2 period", last_ref_cyc - prev, VEC[i][0]);
         chk("R4 cs blk0", int'(last_cs), 1);
         repeat (12) tick();
         chk("R3 recovery length", last_act_len, VEC[i][2]);
         send_cmd(3'd2, 1'b0);
      end

      interval_i = 16'(N);
      recov_sel_i = 2'd0;
      // R5: nothing enabled
      c0 = ref_count;
      repeat (3 * N) tick();
      chk("R5 no refresh", ref_count, c0);
      chk("R5 not busy", int'(busy_o), 0);

      // R4: both blocks, then block 1 alone
      send_cmd(3'd1, 1'b0);
      send_cmd(3'd1, 1'b1);
      wait_ref(N + 4);
      chk("R4 cs both", int'(last_cs), 3);
      send_cmd(3'd2, 1'b0);
      wait_ref(N + 4);
      chk("R4 cs blk1", int'(last_cs), 2);

      // R7: self-refresh with a block select that is not enabled
      send_cmd(3'd3, 1'b0);
      chk("R7 self on", int'(self_ref_o), 1);
      chk("R7 busy in self", int'(busy_o), 1);
      c0 = ref_count;
      repeat (3 * N) tick();
      chk("R7 no refresh in self", ref_count, c0);
      send_cmd(3'd4, 1'b0);
      chk("R7 self off", int'(self_ref_o), 0);
      wait_ref(N + 4);
      chk("R7 restart delay", last_ref_cyc - acc_cyc, N);

      // R6: refresh held while sequencer busy
      seq_idle_i = 1'b0;
      c0 = ref_count;
      repeat (3 * N) tick();
      chk("R6 held", ref_count, c0);
      chk("R6 busy", int'(busy_o), 1);
      chk("R6 rdy low", int'(cmd_rdy_o), 0);
      seq_idle_i = 1'b1;
      tick();
      chk("R6 issued on idle", ref_count, c0 + 1);
      prev = last_ref_cyc;
      repeat (N - 4) tick();
      chk("R6 only one", ref_count, c0 + 1);
      wait_ref(N + 4);
      chk("R6 period after", last_ref_cyc - prev, N);

      // R8: entry waits behind a pending refresh
      seq_idle_i = 1'b0;
      repeat (N + 2) tick();
      c0 = ref_count;
      fork
         send_cmd(3'd3, 1'b1);
         begin
            repeat (4) tick();
            chk("R8 entry stalled", int'(self_ref_o), 0);
            seq_idle_i = 1'b1;
         end
      join
      chk("R8 refresh first", ref_count, c0 + 1);
      chk("R8 self after", int'(self_ref_o), 1);
      chk("R8 recovery done", int'(ref_active_o), 0);
      send_cmd(3'd4, 1'b1);
      chk("R7 exit any block", int'(self_ref_o), 0);

      // R9: unused opcode is accepted and harmless
      send_cmd(3'd6, 1'b0);
      chk("R9 nop keeps mode", int'(self_ref_o), 0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule